// File: doc/BRIEF.md
# Dual-Bank Microcode Sequencer

This block is the control unit of a small 16-bit processor, built as a microprogram rather than as hardwired state logic. It has two microcode banks, A and B, of equal depth. Both banks are read at the same next address, which the current microword supplies. A selection step then decides which of the two words goes into the micro-instruction register. That decision comes from a three-bit condition field in the current word and from the datapath status: the flag, the opcode bit, bit 15 of the data bus, and an interrupt request that is gated internally.

The register drives the nine datapath controls, an active-low memory select, a read/write line, the condition field and the next address. The block also keeps the interrupt-enable flip-flop. A memory read of the enable address sets it and a memory write to that address clears it. The microcode is written through a load port, and in practice the bench does this while reset is held. Sequencing only advances on cycles where the bus-cycle enable is high.

Top module: `useq_dual_bank`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, the outputs show bank A word 0, and the interrupt enable is cleared.
- R2: A microword is 24 bits. Bits 23..15 are ctrl[8:0], bit 14 is mem_sel_n, bit 13 is rd_wr_n, bits 12..10 are cond {x,y,z}, and bits 9..0 are next_addr.
- R3: When step_en is low on a clock edge, every output holds its value.
- R4: A write with load_en high stores load_data at load_addr, in bank B when load_bank=1 and in bank A when load_bank=0. A write does not change the outputs directly. A step that reads the same address on the same edge gets the old word.
- R5: When cond[2]=0, a step loads the bank B word at next_addr if cond[0]=1, and the bank A word if cond[0]=0. Status inputs have no effect in this case.
- R6: When cond[2]=1, cond[1:0] chooses the test. The values 00, 01, 10 and 11 select flag_f, op_bit, din15 and the interrupt request. A step loads bank B when the tested signal is 1 and bank A when it is 0.
- R7: The interrupt request equals irq_req AND interrupt-enable AND NOT flag_f.
- R8: On a step where mem_sel_n=0 and bus_addr=0x4000, the interrupt enable becomes rd_wr_n: a read sets it and a write clears it. On any other cycle it keeps its value. The new value takes effect from the next step.
- R9: Status inputs are sampled at the clock edge of the step, and later changes have no effect on the word loaded.
- R10: With the standard seven-address microcode loaded, the sequence from reset behaves as follows. With din15=0 it runs 0x2F3801 → 0x012003 → 0x0AA403 → 0x023404. With din15=1, the first step instead gives 0x947C06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Bus-cycle enable for the micro-instruction register |
| load_en | input | 1 | Microcode write strobe |
| load_bank | input | 1 | Bank select for the write: 0 = A, 1 = B |
| load_addr | input | 10 | Microcode write address |
| load_data | input | 24 | Microcode write data |
| flag_f | input | 1 | Datapath flag |
| op_bit | input | 1 | Opcode bit of the current instruction |
| din15 | input | 1 | Bit 15 of the data input bus |
| irq_req | input | 1 | Interrupt request, active high |
| bus_addr | input | 15 | Memory address presented by the datapath |
| ctrl | output | 9 | Datapath controls s8..s0 |
| mem_sel_n | output | 1 | Memory access, active low |
| rd_wr_n | output | 1 | 1 = read, 0 = write |
| cond | output | 3 | Condition field {x,y,z} |
| next_addr | output | 10 | Next microcode address |

## Verification
Every state bit sits directly on the ports, so a wrong bank choice or a corrupted word shows up in the register one cycle after the faulty step. A wrong interrupt-enable value stays hidden until a step with condition 111 runs while irq_req is high and flag_f is low. The bench uses random microcode and random bus addresses weighted toward 0x4000 so that this situation happens often. The model tracks the enable bit, so a divergence is reported on the first such step.

// File: rtl/useq_dual_bank.sv
module useq_dual_bank #(
  parameter int AW = 10,
  parameter int CW = 9,
  parameter int BUSW = 15,
  parameter logic [BUSW-1:0] IE_ADDR = 15'h4000,
  parameter int WW = CW + 2 + 3 + AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            load_en,
  input  logic            load_bank,
  input  logic [AW-1:0]   load_addr,
  input  logic [WW-1:0]   load_data,
  input  logic            flag_f,
  input  logic            op_bit,
  input  logic            din15,
  input  logic            irq_req,
  input  logic [BUSW-1:0] bus_addr,
  output logic [CW-1:0]   ctrl,
  output logic            mem_sel_n,
  output logic            rd_wr_n,
  output logic [2:0]      cond,
  output logic [AW-1:0]   next_addr
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] bank_a [DEPTH];
  logic [WW-1:0] bank_b [DEPTH];
  logic [WW-1:0] uir_q;
  logic          ie_q;
  logic          int_req;
  logic          take_b;

  always_ff @(posedge clk)
    if (load_en && !load_bank) bank_a[load_addr] <= load_data;

  always_ff @(posedge clk)
    if (load_en && load_bank) bank_b[load_addr] <= load_data;

  assign next_addr = uir_q[AW-1:0];
  assign cond      = uir_q[AW+2:AW];
  assign rd_wr_n   = uir_q[AW+3];
  assign mem_sel_n = uir_q[AW+4];
  assign ctrl      = uir_q[WW-1 -: CW];

  assign int_req = irq_req & ie_q & ~flag_f;

  always_comb begin
    if (!cond[2]) take_b = cond[0];
    else begin
      case (cond[1:0])
        2'b00:   take_b = flag_f;
        2'b01:   take_b = op_bit;
        2'b10:   take_b = din15;
        default: take_b = int_req;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uir_q <= bank_a[0];
      ie_q  <= 1'b0;
    end else if (step_en) begin
      uir_q <= take_b ? bank_b[next_addr] : bank_a[next_addr];
      if (!mem_sel_n && bus_addr == IE_ADDR) ie_q <= rd_wr_n;
    end
  end
endmodule

// File: rtl/useq_dual_bank_chk.sv
module useq_dual_bank_chk #(
  parameter int AW = 10,
  parameter int BUSW = 15,
  parameter logic [BUSW-1:0] IE_ADDR = 15'h4000,
  parameter int WW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_en,
  input logic [BUSW-1:0] bus_addr,
  input logic [WW-1:0]   word,
  input logic            ie_q
);
  logic hit;
  assign hit = step_en && !word[AW+4] && bus_addr == IE_ADDR;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(word));

  a_r8_ie_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit && word[AW+3] |=> ie_q);

  a_r8_ie_clr: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !word[AW+3] |=> !ie_q);

  a_r8_ie_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(ie_q));
endmodule

bind useq_dual_bank useq_dual_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .bus_addr(bus_addr),
  .word(uir_q), .ie_q(ie_q)
);

// File: tb/tb_useq_dual_bank.sv
`timescale 1ns/1ps
module tb_useq_dual_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, load_en = 1'b0, load_bank = 1'b0;
  logic [9:0]  load_addr = '0;
  logic [23:0] load_data = '0;
  logic flag_f = 1'b0, op_bit = 1'b0, din15 = 1'b0, irq_req = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [8:0] ctrl;
  logic mem_sel_n, rd_wr_n;
  logic [2:0] cond;
  logic [9:0] next_addr;

  int n_tests = 0, n_fail = 0;
  logic [23:0] mA [1024];
  logic [23:0] mB [1024];
  logic [23:0] exp_w;
  logic exp_ie;

  always #5 clk = ~clk;

  useq_dual_bank dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
    .load_bank(load_bank), .load_addr(load_addr), .load_data(load_data),
    .flag_f(flag_f), .op_bit(op_bit), .din15(din15), .irq_req(irq_req),
    .bus_addr(bus_addr), .ctrl(ctrl), .mem_sel_n(mem_sel_n),
    .rd_wr_n(rd_wr_n), .cond(cond), .next_addr(next_addr)
  );

  function automatic logic pick_b(logic [2:0] c, logic f, logic op,
                                  logic d15, logic ir, logic ie);
    if (!c[2]) return c[0];
    case (c[1:0])
      2'b00:   return f;
      2'b01:   return op;
      2'b10:   return d15;
      default: return ir & ie & ~f;
    endcase
  endfunction

  function automatic logic [23:0] out_word();
    return {ctrl, mem_sel_n, rd_wr_n, cond, next_addr};
  endfunction

  task automatic check_val(string tag, logic [23:0] want);
    n_tests++;
    if (out_word() !== want) begin
      n_fail++;
      $display("FAIL %s: actual %06h expected %06h", tag, out_word(), want);
    end
  endtask

  // advances one clock: model uses inputs present before the edge
  task automatic tick(string tag);
    logic [23:0] nw;
    logic nie;
    nw = exp_w;
    nie = exp_ie;
    if (!rst_n) begin
      nw = mA[0];
      nie = 1'b0;
    end else if (step_en) begin
      nw = pick_b(exp_w[12:10], flag_f, op_bit, din15, irq_req, exp_ie)
           ? mB[exp_w[9:0]] : mA[exp_w[9:0]];
      if (!exp_w[14] && bus_addr == 15'h4000) nie = exp_w[13];
    end
    if (load_en) begin
      if (load_bank) mB[load_addr] = load_data;
      else mA[load_addr] = load_data;
    end
    @(posedge clk);
    @(negedge clk);
    exp_w = nw;
    exp_ie = nie;
    check_val(tag, exp_w);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mA[0] = 24'h2F3801; mB[0] = 24'h2F3802;
    mA[1] = 24'h012003; mB[1] = 24'h947C06;
    mA[2] = 24'h012003; mB[2] = 24'h906000;
    mA[3] = 24'h0AA403; mB[3] = 24'h023404;
    mA[4] = 24'hB14005; mB[4] = 24'hF14005;
    mA[5] = 24'h2E2405; mB[5] = 24'h101000;
    mA[6] = 24'h846005; mB[6] = 24'h2F3801;
    for (int i = 7; i < 1024; i++) begin
      mA[i] = 24'($urandom);
      mB[i] = 24'($urandom);
    end
    // R4: fill both banks through the load port under reset
    @(negedge clk);
    for (int i = 0; i < 2048; i++) begin
      load_en = 1'b1;
      load_bank = i[10];
      load_addr = i[9:0];
      load_data = i[10] ? mB[i[9:0]] : mA[i[9:0]];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
    exp_w = mA[0];
    exp_ie = 1'b0;
    check_val("R1 reset word", 24'h2F3801);
    n_tests++;
    if (ctrl !== 9'h05E || mem_sel_n !== 1'b0 || rd_wr_n !== 1'b1 ||
        cond !== 3'b110 || next_addr !== 10'd1) begin
      n_fail++;
      $display("FAIL R2 fields: actual %06h expected 05E/0/1/110/001", out_word());
    end

    // R10 standard trace, din15 = 0
    rst_n = 1'b1;
    check_val("R1 after release", 24'h2F3801);
    step_en = 1'b1;
    tick("R10 step1");
    check_val("R10 word1", 24'h012003);
    tick("R10 step2");
    check_val("R10 word2", 24'h0AA403);
    tick("R10 step3");
    check_val("R10 word3", 24'h023404);

    // R3 hold
    step_en = 1'b0; din15 = 1'b1; flag_f = 1'b1;
    tick("R3 hold");
    check_val("R3 hold literal", 24'h023404);

    // R10 din15=1 branch from reset
    rst_n = 1'b0;
    tick("R1 rereset");
    rst_n = 1'b1; step_en = 1'b1; din15 = 1'b1; flag_f = 1'b0;
    tick("R10 d15 branch");
    check_val("R10 d15 literal", 24'h947C06);

    // R9 din15 changes right after the edge
    rst_n = 1'b0;
    tick("R1 rereset2");
    rst_n = 1'b1; din15 = 1'b1;
    @(posedge clk);
    #1 din15 = 1'b0;
    @(negedge clk);
    exp_w = mB[1];
    check_val("R9 sample at edge", 24'h947C06);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      string tag;
      rst_n     = ($urandom_range(0, 199) != 0);
      step_en   = ($urandom_range(0, 3) != 0);
      load_en   = ($urandom_range(0, 9) == 0);
      load_bank = 1'($urandom);
      load_addr = 10'($urandom);
      load_data = 24'($urandom);
      flag_f    = 1'($urandom);
      op_bit    = 1'($urandom);
      din15     = 1'($urandom);
      irq_req   = 1'($urandom);
      bus_addr  = ($urandom_range(0, 1) != 0) ? 15'h4000 : 15'($urandom);
      if (!rst_n) tag = "R1 random reset";
      else if (!step_en) tag = load_en ? "R4 write no step" : "R3 no step";
      else if (!exp_w[14] && bus_addr == 15'h4000) tag = "R8 enable access";
      else if (exp_w[12:10] == 3'b111) tag = "R7 interrupt test";
      else if (exp_w[12]) tag = "R6 status test";
      else tag = "R5 unconditional";
      tick(tag);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule